// File: doc/BRIEF.md
# Buffer Power-Up Sequencer

This block walks a clock buffer from an unpowered state to normal operation. After the supply-good flag rises, it waits for a fixed settling time that is counted in microsecond ticks. It then waits until two things are true: an input reference clock is detected and the power-down pin is released. Only then does it ask the PLL to run. When the PLL reports lock, the sequencer enables the outputs and raises a lock flag. The lock flag is latched: it ignores later loss of PLL lock or of the input clock, and falls only on power-down or supply loss.

A small activity detector watches the reference clock after synchronising it. It declares the clock present after a set number of rising edges that arrive with no gap longer than a miss limit. It declares the clock absent when no edge arrives within that miss limit. If the PLL does not lock within a timeout, the run request drops for one cycle and is then raised again, so the PLL gets a fresh start instead of hanging.

Releasing power-down after a power-down period sends the sequencer straight back to the wait state without a new settling delay. Losing the supply returns it to the off state from anywhere.

Top module: `pwrseq_top`

## Requirements
- R1: While reset is asserted and right after it, `outEnable`, `lockOut` and `pllRun` are 0.
- R2: While `supplyGood` is 0, all three outputs are 0, and `pllRun` is 0 one cycle after `supplyGood` is seen low.
- R3: `outEnable` does not rise until at least `SETTLE_US` ticks of `usTick` have occurred with `supplyGood` continuously high.
- R4: `pllRun` is raised only after settling, with the reference clock present and `pwrDownN` high (1 = released). Outputs stay disabled with no reference clock even when the supply and power-down are both valid.
- R5: The reference clock counts as present after `DETECT_EDGES` rising edges with no gap of `MISS_CYCLES` clock cycles between them. It counts as absent after `MISS_CYCLES` cycles with no edge. Short bursts of fewer edges never start the PLL.
- R6: The sequencer enters normal operation when the PLL reports lock while `pllRun` is high. `outEnable` and `lockOut` rise in the same cycle and are always equal.
- R7: Once set, `lockOut` stays 1 when the PLL lock indication falls or the reference clock stops.
- R8: Pulling `pwrDownN` low in normal operation clears `lockOut` and `outEnable` within 4 cycles and returns the sequencer to the wait state.
- R9: If lock does not arrive within `LOCK_TMO_US` ticks of `pllRun`, `pllRun` drops for exactly one cycle and is then raised again.
- R10: Loss of `supplyGood` in any state clears `lockOut` and `outEnable` on the next edge and returns to the off state.
- R11: Relocking after a power-down release skips the settling delay: lock returns in fewer than `SETTLE_US` cycles when the clock and PLL are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyGood | input | 1 | Supply above threshold, synchronous to clk |
| refClkIn | input | 1 | Raw reference clock, synchronised inside |
| pwrDownN | input | 1 | Power-down pin, low = power down, asynchronous |
| pllLockedRaw | input | 1 | Raw PLL lock indication, asynchronous |
| usTick | input | 1 | One-cycle pulse each microsecond |
| outEnable | output | 1 | Enable to the output gating stage |
| lockOut | output | 1 | Latched lock flag |
| pllRun | output | 1 | Request for the PLL to run |

## Verification
The properties assume that `supplyGood` and `usTick` are synchronous to `clk`, and that `usTick` is a single-cycle pulse. They also assume that the reference clock runs slower than half the sequencer clock, so that the synchroniser sees every edge. The stimulus changes every input on the falling edge of `clk` and toggles the reference clock at most once per cycle, which gives one rising edge every two cycles. The tick pulses come from a divider whose ratio the bench sets per test. The lock-cause property allows for the two-stage synchroniser delay on `pwrDownN`, so the stimulus holds power-down for several cycles rather than pulsing it.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RUN    = 2'd3
  } seqState_t;

  // strobes from the sequencer control to its datapath
  typedef struct packed {
    logic settleRun;
    logic pllReq;
    logic tmoClr;
    logic lockSet;
    logic lockClr;
  } seqStrobe_t;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_dpath.sv
module pwrseq_dpath
  import pwrseq_pkg::*;
#(
  parameter int SETTLE_US    = 250,
  parameter int DETECT_EDGES = 8,
  parameter int MISS_CYCLES  = 64,
  parameter int LOCK_TMO_US  = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refClkIn,
  input  logic       pwrDownN,
  input  logic       pllLockedRaw,
  input  logic       usTick,
  input  seqStrobe_t strobe,
  output logic       settleDone,
  output logic       clkPresent,
  output logic       pdActive,
  output logic       pllLocked,
  output logic       lockTmo,
  output logic       pllRun,
  output logic       lockOut
);
  localparam int SET_W  = $clog2(SETTLE_US + 1);
  localparam int EDGE_W = $clog2(DETECT_EDGES + 1);
  localparam int MISS_W = $clog2(MISS_CYCLES + 1);
  localparam int TMO_W  = $clog2(LOCK_TMO_US + 1);
  localparam logic [SET_W-1:0]  SET_END   = SET_W'(SETTLE_US);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(DETECT_EDGES - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_CYCLES - 1);
  localparam logic [TMO_W-1:0]  TMO_END   = TMO_W'(LOCK_TMO_US);

  logic refSync, refPrev, refEdge, pdSync;
  logic [SET_W-1:0]  settleCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [MISS_W-1:0] missCnt;
  logic [TMO_W-1:0]  tmoCnt;

  pwrseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uRefSync (
    .clk(clk), .rstN(rstN), .din(refClkIn), .dout(refSync));
  pwrseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uPdSync (
    .clk(clk), .rstN(rstN), .din(pwrDownN), .dout(pdSync));
  pwrseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uLockSync (
    .clk(clk), .rstN(rstN), .din(pllLockedRaw), .dout(pllLocked));

  assign pdActive = ~pdSync;
  assign refEdge  = refSync & ~refPrev;

  // reference clock activity detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev    <= 1'b0;
      edgeCnt    <= '0;
      missCnt    <= '0;
      clkPresent <= 1'b0;
    end else begin
      refPrev <= refSync;
      if (refEdge) begin
        missCnt <= '0;
        if (!clkPresent) begin
          if (edgeCnt == EDGE_LAST) begin
            clkPresent <= 1'b1;
            edgeCnt    <= '0;
          end else begin
            edgeCnt <= edgeCnt + 1'b1;
          end
        end
      end else if (missCnt != MISS_LAST) begin
        missCnt <= missCnt + 1'b1;
      end else begin
        clkPresent <= 1'b0;
        edgeCnt    <= '0;
      end
    end
  end

  // settling delay in microsecond ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               settleCnt <= '0;
    else if (!strobe.settleRun)              settleCnt <= '0;
    else if (usTick && settleCnt != SET_END) settleCnt <= settleCnt + 1'b1;
  end
  assign settleDone = (settleCnt == SET_END);

  // lock timeout while the PLL is requested but not locked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     tmoCnt <= '0;
    else if (strobe.tmoClr || !pllRun || pllLocked) tmoCnt <= '0;
    else if (usTick && tmoCnt != TMO_END)          tmoCnt <= tmoCnt + 1'b1;
  end
  assign lockTmo = (tmoCnt == TMO_END);

  // PLL request and latched lock flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllRun  <= 1'b0;
      lockOut <= 1'b0;
    end else begin
      pllRun <= strobe.pllReq;
      if (strobe.lockClr)      lockOut <= 1'b0;
      else if (strobe.lockSet) lockOut <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       settleDone,
  input  logic       clkPresent,
  input  logic       pdActive,
  input  logic       pllLocked,
  input  logic       lockTmo,
  input  logic       pllRun,
  output seqStrobe_t strobe,
  output logic       outEnable
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_OFF: begin
        if (supplyGood) stateNext = ST_SETTLE;
      end
      ST_SETTLE: begin
        strobe.settleRun = 1'b1;
        if (settleDone) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (clkPresent && !pdActive) begin
          if (pllRun && pllLocked) begin
            stateNext      = ST_RUN;
            strobe.lockSet = 1'b1;
            strobe.pllReq  = 1'b1;
          end else if (lockTmo) begin
            strobe.tmoClr = 1'b1;
          end else begin
            strobe.pllReq = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (pdActive) begin
          stateNext      = ST_WAIT;
          strobe.lockClr = 1'b1;
        end else begin
          strobe.pllReq = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase
    if (!supplyGood) begin
      stateNext      = ST_OFF;
      strobe         = '0;
      strobe.lockClr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign outEnable = (state == ST_RUN);
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int SETTLE_US    = 250,
  parameter int DETECT_EDGES = 8,
  parameter int MISS_CYCLES  = 64,
  parameter int LOCK_TMO_US  = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic refClkIn,
  input  logic pwrDownN,
  input  logic pllLockedRaw,
  input  logic usTick,
  output logic outEnable,
  output logic lockOut,
  output logic pllRun
);
  seqStrobe_t strobe;
  logic settleDone, clkPresent, pdActive, pllLocked, lockTmo;

  pwrseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .settleDone(settleDone),
    .clkPresent(clkPresent), .pdActive(pdActive), .pllLocked(pllLocked),
    .lockTmo(lockTmo), .pllRun(pllRun), .strobe(strobe), .outEnable(outEnable));

  pwrseq_dpath #(
    .SETTLE_US(SETTLE_US), .DETECT_EDGES(DETECT_EDGES),
    .MISS_CYCLES(MISS_CYCLES), .LOCK_TMO_US(LOCK_TMO_US), .SYNC_STAGES(2)
  ) uDpath (
    .clk(clk), .rstN(rstN), .refClkIn(refClkIn), .pwrDownN(pwrDownN),
    .pllLockedRaw(pllLockedRaw), .usTick(usTick), .strobe(strobe),
    .settleDone(settleDone), .clkPresent(clkPresent), .pdActive(pdActive),
    .pllLocked(pllLocked), .lockTmo(lockTmo), .pllRun(pllRun), .lockOut(lockOut));
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int SETTLE_US = 250
) (
  input logic clk,
  input logic rstN,
  input logic supplyGood,
  input logic pwrDownN,
  input logic usTick,
  input logic outEnable,
  input logic lockOut,
  input logic pllRun
);
  localparam int GW = $clog2(SETTLE_US + 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(SETTLE_US);
  logic [GW-1:0] goodTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               goodTicks <= '0;
    else if (!supplyGood)                    goodTicks <= '0;
    else if (usTick && goodTicks != GOOD_MAX) goodTicks <= goodTicks + 1'b1;
  end

  assert_lock_eq_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockOut == outEnable);

  assert_lock_fall_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockOut) |-> (!$past(supplyGood) || !$past(pwrDownN, 2) || !$past(pwrDownN, 3)));

  assert_supply_loss_R10: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> (!pllRun && !lockOut && !outEnable));

  assert_enable_needs_request_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> $past(pllRun));

  assert_settle_min_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> (goodTicks == GOOD_MAX));
endmodule

bind pwrseq_top pwrseq_chk #(.SETTLE_US(SETTLE_US)) uChk (
  .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .pwrDownN(pwrDownN),
  .usTick(usTick), .outEnable(outEnable), .lockOut(lockOut), .pllRun(pllRun));

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;
  localparam int SETTLE  = 20;
  localparam int EDGES   = 4;
  localparam int MISS    = 16;
  localparam int LOCKTMO = 30;

  logic clk = 1'b0, rstN = 1'b0;
  logic supplyGood = 1'b0, refClkIn = 1'b0, pwrDownN = 1'b1, pllLockedRaw = 1'b0, usTick = 1'b0;
  logic outEnable, lockOut, pllRun;
  logic clkOn = 1'b0;
  int tickDiv = 1, tickCnt = 0, tickTotal = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwrseq_top #(.SETTLE_US(SETTLE), .DETECT_EDGES(EDGES), .MISS_CYCLES(MISS),
               .LOCK_TMO_US(LOCKTMO)) u0 (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .refClkIn(refClkIn),
    .pwrDownN(pwrDownN), .pllLockedRaw(pllLockedRaw), .usTick(usTick),
    .outEnable(outEnable), .lockOut(lockOut), .pllRun(pllRun));

  always @(negedge clk) begin
    if (clkOn) refClkIn <= ~refClkIn;
    else       refClkIn <= 1'b0;
    if (tickCnt >= tickDiv - 1) begin tickCnt <= 0; usTick <= 1'b1; end
    else begin tickCnt <= tickCnt + 1; usTick <= 1'b0; end
  end
  always @(posedge clk) if (usTick) tickTotal <= tickTotal + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic sg; logic pd; logic ck; logic pl;
    logic [31:0] hold;
    logic expLock; logic expOe; logic expRun;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0,1'b1,1'b1,1'b1, 32'd80, 1'b0,1'b0,1'b0, 4'd2},  // R2 supply off
    '{1'b1,1'b0,1'b0,1'b1, 32'd80, 1'b0,1'b0,1'b0, 4'd4},  // R4 power-down held
    '{1'b1,1'b1,1'b0,1'b1, 32'd80, 1'b0,1'b0,1'b0, 4'd4},  // R4 no reference clock
    '{1'b1,1'b1,1'b1,1'b0, 32'd25, 1'b0,1'b0,1'b1, 4'd5},  // R5 clock found, PLL requested
    '{1'b1,1'b1,1'b1,1'b1, 32'd10, 1'b1,1'b1,1'b1, 4'd6},  // R6 lock reached
    '{1'b1,1'b1,1'b1,1'b0, 32'd40, 1'b1,1'b1,1'b1, 4'd7},  // R7 PLL lock lost
    '{1'b1,1'b1,1'b0,1'b0, 32'd40, 1'b1,1'b1,1'b1, 4'd7},  // R7 reference clock lost
    '{1'b1,1'b0,1'b1,1'b1, 32'd20, 1'b0,1'b0,1'b0, 4'd8},  // R8 power-down
    '{1'b1,1'b1,1'b1,1'b1, 32'd10, 1'b1,1'b1,1'b1, 4'd11}, // R11 relock without settling
    '{1'b0,1'b1,1'b1,1'b1, 32'd5,  1'b0,1'b0,1'b0, 4'd10}, // R10 supply loss
    '{1'b1,1'b1,1'b1,1'b1, 32'd60, 1'b1,1'b1,1'b1, 4'd3}   // R3 full power-up again
  };

  initial begin
    int t0, n, falls, lastFall, lowLen, minGap, badLow;
    bit prevRun, sawRun;
    // R1 reset state
    cyc(3);
    chk(!outEnable && !lockOut && !pllRun, "R1 during reset", {outEnable,lockOut,pllRun}, 0);
    rstN = 1'b1;
    cyc(2);
    chk(!outEnable && !lockOut && !pllRun, "R1 after reset", {outEnable,lockOut,pllRun}, 0);

    foreach (VECS[i]) begin
      supplyGood = VECS[i].sg; pwrDownN = VECS[i].pd;
      clkOn = VECS[i].ck; pllLockedRaw = VECS[i].pl;
      cyc(int'(VECS[i].hold));
      chk({lockOut,outEnable,pllRun} == {VECS[i].expLock,VECS[i].expOe,VECS[i].expRun},
          $sformatf("R%0d row %0d", VECS[i].req, i), {lockOut,outEnable,pllRun},
          {VECS[i].expLock,VECS[i].expOe,VECS[i].expRun});
    end

    // R3 settle delay with slow ticks
    supplyGood = 1'b0; cyc(5);
    chk(!lockOut && !pllRun, "R2 supply low", {lockOut,pllRun}, 0);
    tickDiv = 3;
    supplyGood = 1'b1;
    t0 = tickTotal; n = 0;
    while (!lockOut && n < 200) begin
      cyc(1); n++;
      if (lockOut != outEnable) chk(0, "R6 lock equals enable", lockOut, outEnable);
    end
    chk(lockOut, "R3 lock after settle", lockOut, 1);
    chk(tickTotal - t0 >= SETTLE, "R3 ticks before enable", tickTotal - t0, SETTLE);
    chk(n <= 3*SETTLE + 30, "R3 power-up latency", n, 3*SETTLE + 30);
    tickDiv = 1;

    // R8 power-down latency
    pwrDownN = 1'b0; n = 0;
    while (lockOut && n < 20) begin cyc(1); n++; end
    chk(!lockOut && !outEnable && n <= 4, "R8 clear latency", n, 4);

    // R9 lock timeout restart
    pllLockedRaw = 1'b0; cyc(5); pwrDownN = 1'b1;
    falls = 0; lastFall = -1; lowLen = 0; minGap = 1000; badLow = 0; prevRun = pllRun;
    for (int c = 0; c < 200; c++) begin
      cyc(1);
      if (prevRun && !pllRun) begin
        if (lastFall >= 0 && c - lastFall < minGap) minGap = c - lastFall;
        falls++; lastFall = c; lowLen = 0;
      end
      if (!pllRun) lowLen++;
      if (prevRun == 1'b0 && pllRun && lowLen > 1 && falls > 0) badLow++;
      if (pllRun) lowLen = 0;
      if (lockOut) chk(0, "R4 no lock without PLL", lockOut, 0);
      prevRun = pllRun;
    end
    chk(falls >= 3, "R9 restart count", falls, 3);
    chk(badLow == 0, "R9 one-cycle drop", badLow, 0);
    chk(minGap >= LOCKTMO, "R9 restart interval", minGap, LOCKTMO);

    // R5 short bursts never start the PLL
    clkOn = 1'b0; cyc(40);
    chk(!pllRun, "R5 clock absent", pllRun, 0);
    pllLockedRaw = 1'b1; sawRun = 0;
    for (int b = 0; b < 4; b++) begin
      clkOn = 1'b1; cyc(3); clkOn = 1'b0;
      for (int c = 0; c < 30; c++) begin cyc(1); if (pllRun || lockOut) sawRun = 1; end
    end
    chk(!sawRun, "R5 bursts ignored", sawRun, 0);
    clkOn = 1'b1; cyc(30);
    chk(lockOut && outEnable, "R5 steady clock locks", lockOut, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule